// File: doc/BRIEF.md
# Clock Frequency Selection Controller

This block chooses the frequency setting that a clock synthesizer runs at. Several sources compete for that choice. The first is a five-bit strap code sampled from the board once, just after reset. The second is a software select code. The third is a pair of programmable multiplier and divider values, N and M, which set the output frequency as G·(N+3)/(M+3). The fourth is a fallback setting that a watchdog can force when the system stops responding.

An override bit picks whether the five-bit gear and ratio index comes from the strap or from the software code. This rule applies in every mode, including programmable mode.

A programmable enable bit makes the synthesizer use an N/M pair. That pair is the last one written with a legal ratio, meaning N strictly greater than M. Each legal write to either value produces a single-cycle change pulse. A write that updates both values in the same cycle produces only one pulse.

A watchdog recovery request latches a recovery state that outranks all other sources. Its source bit selects one of two settings: the strap index, or a separate recovery N/M pair. The recovery state stays in force until software clears it.

Top module: `clk_freq_selector`

## Requirements
- R1: The strap input is sampled at the first rising clock edge after reset is released. The sampled value is held until the next reset and is shown on `strap_word`. Later changes on `strap_in` have no effect on it.
- R2: With `prog_en`=0 and no recovery active, `gear_idx` equals `strap_word` when `ovr`=0 and equals `sw_sel` when `ovr`=1. `prog_mode` is 0.
- R3: With `prog_en`=1 and no recovery active, `prog_mode` is 1. `act_n` and `act_m` show the last legally written pair, which is N=1, M=0 after reset. `gear_idx` still follows the `ovr` rule of R2.
- R4: A pair with `n_val` <= `m_val` is illegal. While `prog_en`=1, such a pair raises `ratio_bad` in the same cycle. A write strobe carrying an illegal pair changes neither `act_n` nor `act_m` and produces no change pulse. The boundary case N equal to M is illegal.
- R5: A legal write strobe outside recovery makes `freq_chg` high for exactly the one cycle after the strobe edge. The strobe can be `wr_n`, `wr_m`, or both in the same cycle, and all three cases give one pulse.
- R6: A `wdt_expire` pulse while not recovering sets `rcv_active` and pulses `freq_chg` at the next edge. With `rcv_src`=0, `gear_idx` is then `strap_word` regardless of `ovr`, and `prog_mode` is 0.
- R7: During recovery with `rcv_src`=1 and `rcv_n` > `rcv_m`, `prog_mode` is 1 and `act_n`/`act_m` show the recovery pair. `gear_idx` follows the `ovr` rule. If the recovery pair is illegal, the block falls back to the strap index with `prog_mode`=0.
- R8: Recovery stays active until `wdt_clr` is seen. A `wdt_expire` in the same cycle as `wdt_clr` keeps recovery active. Leaving recovery pulses `freq_chg` once and restores the R2/R3 selection. Legal writes made during recovery are stored but do not pulse.
- R9: Index codes 16, 17 and 18 (binary 10000, 10001, 10010) are reserved. `sel_bad` is 1 exactly when `gear_idx` holds one of them. Codes 15 and 19 are valid.
- R10: During reset and just after it, `freq_chg`=0, `rcv_active`=0, `act_n`=1 and `act_m`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_in | input | 5 | Board strap code, sampled once after reset |
| sw_sel | input | 5 | Software select code |
| ovr | input | 1 | 1: software code supplies the index; 0: strap supplies it |
| prog_en | input | 1 | Enables N/M programmable mode |
| n_val | input | 8 | Programmable N field |
| m_val | input | 7 | Programmable M field |
| wr_n | input | 1 | Write strobe qualifying a new N value |
| wr_m | input | 1 | Write strobe qualifying a new M value |
| rcv_src | input | 1 | Recovery source: 0 strap, 1 recovery N/M |
| rcv_n | input | 8 | Recovery N field |
| rcv_m | input | 7 | Recovery M field |
| wdt_expire | input | 1 | Watchdog recovery request pulse |
| wdt_clr | input | 1 | Software clear of the watchdog status |
| gear_idx | output | 5 | Active gear and ratio index |
| act_n | output | 8 | Active N value |
| act_m | output | 7 | Active M value |
| prog_mode | output | 1 | Active setting uses N/M |
| freq_chg | output | 1 | One-cycle frequency-change pulse |
| ratio_bad | output | 1 | Programmed pair violates N > M |
| sel_bad | output | 1 | Active index is a reserved code |
| rcv_active | output | 1 | Recovery override in force |
| strap_word | output | 5 | Captured strap value |

## Verification
A corrupted strap capture shows up on `strap_word` and `gear_idx` one cycle after reset release, and stays visible for the whole run. A stale or wrongly loaded N/M pair appears on `act_n`/`act_m` at the edge right after the offending strobe. A lost or duplicated change pulse is caught by sampling `freq_chg` both in the cycle after a strobe and in the cycle after that. A recovery state that is stuck or dropped changes `gear_idx` and `prog_mode` at once, and the bench checks both over several idle cycles and across simultaneous set and clear requests.

// File: rtl/clk_freq_selector.sv
module clk_freq_selector #(
  parameter int IW = 5,
  parameter int NW = 8,
  parameter int MW = 7,
  parameter logic [IW-1:0] RSV_LO = IW'(16),
  parameter logic [IW-1:0] RSV_HI = IW'(18)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] strap_in,
  input  logic [IW-1:0] sw_sel,
  input  logic          ovr,
  input  logic          prog_en,
  input  logic [NW-1:0] n_val,
  input  logic [MW-1:0] m_val,
  input  logic          wr_n,
  input  logic          wr_m,
  input  logic          rcv_src,
  input  logic [NW-1:0] rcv_n,
  input  logic [MW-1:0] rcv_m,
  input  logic          wdt_expire,
  input  logic          wdt_clr,
  output logic [IW-1:0] gear_idx,
  output logic [NW-1:0] act_n,
  output logic [MW-1:0] act_m,
  output logic          prog_mode,
  output logic          freq_chg,
  output logic          ratio_bad,
  output logic          sel_bad,
  output logic          rcv_active,
  output logic [IW-1:0] strap_word
);
  localparam int CW = ((NW > MW) ? NW : MW) + 1;

  logic [IW-1:0] strap_q;
  logic          captured;
  logic [NW-1:0] app_n;
  logic [MW-1:0] app_m;
  logic          rcv_q;
  logic          chg_q;

  wire wr_any     = wr_n | wr_m;
  wire nm_ok      = CW'(n_val) > CW'(m_val);
  wire rcv_ok     = CW'(rcv_n) > CW'(rcv_m);
  wire load       = wr_any & nm_ok;
  wire enter      = wdt_expire & ~rcv_q;
  wire leave      = wdt_clr & rcv_q & ~wdt_expire;
  wire chg_d      = (load & ~rcv_q) | enter | leave;
  wire rcv_use_nm = rcv_q & rcv_src & rcv_ok;
  wire rcv_strap  = rcv_q & ~rcv_use_nm;

  wire [IW-1:0] norm_idx = ovr ? sw_sel : strap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q  <= '0;
      captured <= 1'b0;
      app_n    <= NW'(1);
      app_m    <= '0;
      rcv_q    <= 1'b0;
      chg_q    <= 1'b0;
    end else begin
      if (!captured) begin
        strap_q  <= strap_in;
        captured <= 1'b1;
      end
      if (load) begin
        app_n <= n_val;
        app_m <= m_val;
      end
      if (wdt_expire)   rcv_q <= 1'b1;
      else if (wdt_clr) rcv_q <= 1'b0;
      chg_q <= chg_d;
    end
  end

  assign gear_idx   = rcv_strap ? strap_q : norm_idx;
  assign prog_mode  = rcv_use_nm | (~rcv_q & prog_en);
  assign act_n      = rcv_use_nm ? rcv_n : app_n;
  assign act_m      = rcv_use_nm ? rcv_m : app_m;
  assign freq_chg   = chg_q;
  assign ratio_bad  = prog_en & ~nm_ok;
  assign sel_bad    = (gear_idx >= RSV_LO) && (gear_idx <= RSV_HI);
  assign rcv_active = rcv_q;
  assign strap_word = strap_q;

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> $stable(strap_q)); // R1
  AST_PROG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |-> (CW'(act_n) > CW'(act_m))); // R3
  AST_BAD_KEPT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !nm_ok) |=> ($stable(app_n) && $stable(app_m))); // R4
  AST_CHG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && nm_ok && !rcv_q) |=> freq_chg); // R5
  AST_RCV_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_expire && !rcv_q) |=> (rcv_active && freq_chg)); // R6
  AST_RCV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_q && !wdt_clr) |=> rcv_active); // R8
endmodule

// File: tb/clk_freq_selector_tb.sv
module clk_freq_selector_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] strap_in = 5'd29;
  logic [4:0] sw_sel = '0;
  logic       ovr = 1'b0, prog_en = 1'b0;
  logic [7:0] n_val = '0;
  logic [6:0] m_val = '0;
  logic       wr_n = 1'b0, wr_m = 1'b0, rcv_src = 1'b0;
  logic [7:0] rcv_n = '0;
  logic [6:0] rcv_m = '0;
  logic       wdt_expire = 1'b0, wdt_clr = 1'b0;
  logic [4:0] gear_idx, strap_word;
  logic [7:0] act_n;
  logic [6:0] act_m;
  logic       prog_mode, freq_chg, ratio_bad, sel_bad, rcv_active;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  clk_freq_selector u_dut (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .sw_sel(sw_sel), .ovr(ovr),
    .prog_en(prog_en), .n_val(n_val), .m_val(m_val), .wr_n(wr_n), .wr_m(wr_m),
    .rcv_src(rcv_src), .rcv_n(rcv_n), .rcv_m(rcv_m), .wdt_expire(wdt_expire),
    .wdt_clr(wdt_clr), .gear_idx(gear_idx), .act_n(act_n), .act_m(act_m),
    .prog_mode(prog_mode), .freq_chg(freq_chg), .ratio_bad(ratio_bad),
    .sel_bad(sel_bad), .rcv_active(rcv_active), .strap_word(strap_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {prog_en, ovr, sw_sel[5], exp_idx[5], exp_prog, exp_sel_bad}
  localparam logic [13:0] VEC [9] = '{
    {1'b0, 1'b0, 5'd3,  5'd29, 1'b0, 1'b0},
    {1'b0, 1'b1, 5'd3,  5'd3,  1'b0, 1'b0},
    {1'b0, 1'b1, 5'd16, 5'd16, 1'b0, 1'b1},
    {1'b0, 1'b1, 5'd17, 5'd17, 1'b0, 1'b1},
    {1'b0, 1'b1, 5'd18, 5'd18, 1'b0, 1'b1},
    {1'b0, 1'b1, 5'd19, 5'd19, 1'b0, 1'b0},
    {1'b0, 1'b1, 5'd15, 5'd15, 1'b0, 1'b0},
    {1'b1, 1'b0, 5'd16, 5'd29, 1'b1, 1'b0},
    {1'b1, 1'b1, 5'd5,  5'd5,  1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R10 reset freq_chg", freq_chg, 0);
    chk("R10 reset rcv_active", rcv_active, 0);
    chk("R10 reset act_n", act_n, 1);
    chk("R10 reset act_m", act_m, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 strap captured", strap_word, 29);
    strap_in = 5'd7;
    tick();
    tick();
    chk("R1 strap held", strap_word, 29);

    for (int i = 0; i < 9; i++) begin
      prog_en = VEC[i][13];
      ovr     = VEC[i][12];
      sw_sel  = VEC[i][11:7];
      #1;
      chk(VEC[i][13] ? "R3 vector idx" : "R2 vector idx", gear_idx, VEC[i][6:2]);
      chk("R2/R3 vector prog_mode", prog_mode, VEC[i][1]);
      chk("R9 vector sel_bad", sel_bad, VEC[i][0]);
    end
    chk("R3 default act_n", act_n, 1);

    // R5: both strobes in one cycle give one pulse
    prog_en = 1'b1; ovr = 1'b1; sw_sel = 5'd5;
    n_val = 8'd100; m_val = 7'd48; wr_n = 1'b1; wr_m = 1'b1;
    tick();
    wr_n = 1'b0; wr_m = 1'b0;
    chk("R5 pulse after word write", freq_chg, 1);
    chk("R3 act_n loaded", act_n, 100);
    chk("R3 act_m loaded", act_m, 48);
    tick();
    chk("R5 single pulse", freq_chg, 0);

    n_val = 8'd120; wr_n = 1'b1;
    tick();
    wr_n = 1'b0;
    chk("R5 pulse after N write", freq_chg, 1);
    chk("R3 act_n updated", act_n, 120);
    tick();

    // R4 illegal pairs
    n_val = 8'd40; #1;
    chk("R4 ratio_bad N<M", ratio_bad, 1);
    wr_m = 1'b1;
    tick();
    wr_m = 1'b0;
    chk("R4 no pulse on bad write", freq_chg, 0);
    chk("R4 act_n kept", act_n, 120);
    chk("R4 act_m kept", act_m, 48);
    n_val = 8'd48; #1;
    chk("R4 ratio_bad N==M", ratio_bad, 1);
    n_val = 8'd120; #1;
    chk("R4 ratio_ok", ratio_bad, 0);

    // R6 recovery to strap
    rcv_src = 1'b0; wdt_expire = 1'b1;
    tick();
    wdt_expire = 1'b0;
    chk("R6 rcv_active set", rcv_active, 1);
    chk("R6 entry pulse", freq_chg, 1);
    chk("R6 idx strap despite ovr", gear_idx, 29);
    chk("R6 prog_mode off", prog_mode, 0);
    tick(); tick(); tick();
    chk("R8 recovery persists", rcv_active, 1);
    chk("R8 no extra pulse", freq_chg, 0);

    n_val = 8'd130; wr_n = 1'b1;
    tick();
    wr_n = 1'b0;
    chk("R8 write in recovery no pulse", freq_chg, 0);

    // R7 recovery N/M
    rcv_src = 1'b1; rcv_n = 8'd200; rcv_m = 7'd93; #1;
    chk("R7 prog_mode", prog_mode, 1);
    chk("R7 act_n", act_n, 200);
    chk("R7 act_m", act_m, 93);
    chk("R7 idx by ovr", gear_idx, 5);
    rcv_n = 8'd10; #1;
    chk("R7 bad pair falls back idx", gear_idx, 29);
    chk("R7 bad pair prog_mode", prog_mode, 0);
    rcv_n = 8'd200;

    // R8 set wins over clear, then clear
    wdt_expire = 1'b1; wdt_clr = 1'b1;
    tick();
    wdt_expire = 1'b0;
    chk("R8 set beats clear", rcv_active, 1);
    chk("R8 no pulse when staying", freq_chg, 0);
    tick();
    wdt_clr = 1'b0;
    chk("R8 cleared", rcv_active, 0);
    chk("R8 exit pulse", freq_chg, 1);
    chk("R8 idx restored", gear_idx, 5);
    chk("R8 stored write applied", act_n, 130);
    chk("R8 prog_mode restored", prog_mode, 1);
    tick();
    chk("R8 exit pulse single", freq_chg, 0);

    done = 1'b1;
    finish_run();
  end
endmodule